// File: doc/BRIEF.md
# Run-Time Selectable Gray-Coded Phase Mapper

This block turns a serial stream of bits into phase symbols for two-, four- or eight-point phase-shift keying. A two-bit order select gives the group size: one, two or three bits per symbol. Bits arrive one per handshake on a valid/ready input. The block gathers a full group and then emits one symbol. The symbol carries a 4-bit phase index on a 22.5° grid, the signed 16-bit cosine and sine of that phase, and the group size it was built with.

Both stream edges use valid/ready. An input bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high. A symbol leaves on an edge where `sym_valid` and `sym_ready` are both high. The output stage holds a single symbol. `bit_ready` is high only while that stage is empty or is draining in the same cycle, so back-pressure passes straight through to the bit source and no bit is dropped. The order select is a plain control pin. It is sampled when the first bit of each group is taken.

Top module: `psk_mapper_top`

## Requirements
- R1: After reset `sym_valid` is 0 and `bit_ready` is 1.
- R2: `mode_sel` gives the group size: 2'b01 means 1 bit, 2'b10 means 2 bits, 2'b11 means 3 bits, and 2'b00 is treated as 1 bit. `sym_order` reports the group size of the symbol on the output (1, 2 or 3).
- R3: The first bit taken in a group is the most significant bit of that group's label.
- R4: With a group size of 1, label 0 gives phase index 0 and label 1 gives phase index 8. The phase in degrees is the index times 22.5.
- R5: With a group size of 2, labels 11, 01, 00 and 10 give phase indices 2, 6, 10 and 14.
- R6: With a group size of 3, labels 111, 101, 100, 110, 010, 000, 001 and 011 give phase indices 1, 3, 5, 7, 9, 11, 13 and 15.
- R7: `sym_cos` and `sym_sin` are the nearest integers to 32767·cos(k·22.5°) and 32767·sin(k·22.5°), where k is `sym_phase`.
- R8: The symbol appears on the output, with `sym_valid` high, in the cycle right after the edge that takes the last bit of its group.
- R9: The group size is captured with the first bit of each group. A change of `mode_sel` while a group is partly gathered only takes effect from the next group on.
- R10: While `sym_valid` is high and `sym_ready` is low, the output holds stable and `bit_ready` is low. Every bit taken ends up in exactly one emitted symbol, in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Bits per symbol select |
| bit_valid | input | 1 | Input bit present |
| bit_data | input | 1 | Input bit value |
| bit_ready | output | 1 | Block can take a bit this cycle |
| sym_valid | output | 1 | Symbol present on output |
| sym_ready | input | 1 | Sink takes the symbol this cycle |
| sym_phase | output | 4 | Phase index, steps of 22.5° |
| sym_cos | output | 16 | Signed cosine of the phase |
| sym_sin | output | 16 | Signed sine of the phase |
| sym_order | output | 2 | Group size the symbol was built from |

## Verification
The bench targets mode changes that land in the middle of a group. A design that applied the new size at once would cut the group short or stretch it, and every later symbol would then be shifted. It holds the output sink back while bits keep arriving. A design that ignored the held slot would overwrite a symbol or swallow a bit, and the reference queue would then run out of step. The bench also drives the all-zero select and every label of each order, once in bit order, because a reversed bit order or a wrong map entry only shows on some labels.

// File: rtl/psk_pkg.sv
package psk_pkg;
  localparam int ORD_W = 2;
  localparam int LBL_W = 3;
  localparam int PH_W  = 4;
  localparam int AMP_W = 16;
  localparam int QTR   = 1 << (PH_W - 2);

  function automatic logic [ORD_W-1:0] sel_to_order(input logic [1:0] sel);
    return (sel == 2'b00) ? ORD_W'(1) : ORD_W'(sel);
  endfunction

  function automatic logic signed [AMP_W-1:0] quarter_amp(input int unsigned step);
    case (step)
      0: return AMP_W'(32767);
      1: return AMP_W'(30273);
      2: return AMP_W'(23170);
      3: return AMP_W'(12539);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/psk_bit_gather.sv
module psk_bit_gather
  import psk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             grp_done,
  output logic [LBL_W-1:0] grp_label,
  output logic [ORD_W-1:0] grp_order
);
  logic [ORD_W-1:0] cnt_q, ord_q, ord_eff;
  logic [LBL_W-1:0] lbl_q, lbl_nxt;
  logic             take;

  always_comb begin
    in_ready  = slot_free;
    take      = in_valid && slot_free;
    ord_eff   = (cnt_q == '0) ? sel_to_order(mode_sel) : ord_q;
    lbl_nxt   = {lbl_q[LBL_W-2:0], in_bit};
    grp_done  = take && (ORD_W'(cnt_q + 1'b1) == ord_eff);
    grp_label = lbl_nxt;
    grp_order = ord_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lbl_q <= '0;
      ord_q <= ORD_W'(1);
    end else begin
      ord_q <= ord_eff;
      if (take) begin
        if (grp_done) begin
          cnt_q <= '0;
          lbl_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          lbl_q <= lbl_nxt;
        end
      end
    end
  end

  assert_partial_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < ord_q));

  assert_group_size_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (grp_order == ord_q));
endmodule

// File: rtl/psk_label_map.sv
module psk_label_map
  import psk_pkg::*;
(
  input  logic [ORD_W-1:0] order,
  input  logic [LBL_W-1:0] label,
  output logic [PH_W-1:0]  phase
);
  always_comb begin
    phase = '0;
    case (order)
      2'd2: case (label[1:0])
        2'b11: phase = 4'd2;
        2'b01: phase = 4'd6;
        2'b00: phase = 4'd10;
        default: phase = 4'd14;
      endcase
      2'd3: case (label)
        3'b111: phase = 4'd1;
        3'b101: phase = 4'd3;
        3'b100: phase = 4'd5;
        3'b110: phase = 4'd7;
        3'b010: phase = 4'd9;
        3'b000: phase = 4'd11;
        3'b001: phase = 4'd13;
        default: phase = 4'd15;
      endcase
      default: phase = label[0] ? 4'd8 : 4'd0;
    endcase
  end
endmodule

// File: rtl/psk_trig_rom.sv
module psk_trig_rom
  import psk_pkg::*;
(
  input  logic [PH_W-1:0]         phase,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int FULL = 1 << PH_W;
  logic signed [AMP_W-1:0] chan [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [PH_W-1:0] k;
    always_comb begin
      k = phase - PH_W'(ch * QTR);
      if (int'(k) <= QTR)           chan[ch] = quarter_amp(int'(k));
      else if (int'(k) <= 2 * QTR)  chan[ch] = -quarter_amp(2 * QTR - int'(k));
      else if (int'(k) <= 3 * QTR)  chan[ch] = -quarter_amp(int'(k) - 2 * QTR);
      else                          chan[ch] = quarter_amp(FULL - int'(k));
    end
  end

  assign cos_o = chan[0];
  assign sin_o = chan[1];
endmodule

// File: rtl/psk_mapper_top.sv
module psk_mapper_top
  import psk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [PH_W-1:0]   sym_phase,
  output logic [AMP_W-1:0]  sym_cos,
  output logic [AMP_W-1:0]  sym_sin,
  output logic [ORD_W-1:0]  sym_order
);
  logic             slot_free, done;
  logic [LBL_W-1:0] label;
  logic [ORD_W-1:0] order;
  logic [PH_W-1:0]  phase;
  logic signed [AMP_W-1:0] c_val, s_val;

  logic             v_q;
  logic [PH_W-1:0]  ph_q;
  logic [AMP_W-1:0] c_q, s_q;
  logic [ORD_W-1:0] o_q;

  assign slot_free = !v_q || sym_ready;

  psk_bit_gather u_gather (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_valid(bit_valid), .in_bit(bit_data), .slot_free(slot_free),
    .in_ready(bit_ready), .grp_done(done), .grp_label(label), .grp_order(order)
  );

  psk_label_map u_map (.order(order), .label(label), .phase(phase));

  psk_trig_rom u_trig (.phase(phase), .cos_o(c_val), .sin_o(s_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      ph_q <= '0;
      c_q  <= '0;
      s_q  <= '0;
      o_q  <= '0;
    end else if (done) begin
      v_q  <= 1'b1;
      ph_q <= phase;
      c_q  <= c_val;
      s_q  <= s_val;
      o_q  <= order;
    end else if (sym_ready) begin
      v_q <= 1'b0;
    end
  end

  assign sym_valid = v_q;
  assign sym_phase = ph_q;
  assign sym_cos   = c_q;
  assign sym_sin   = s_q;
  assign sym_order = o_q;

  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_phase) && $stable(sym_order)));

  assert_stall_in_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |-> !bit_ready);

  assert_emit_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sym_valid);

  assert_grid_bpsk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_order == 2'd1) |-> (sym_phase[2:0] == 3'd0));

  assert_grid_qpsk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_order == 2'd2) |-> (sym_phase[1:0] == 2'd2));

  assert_grid_8psk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_order == 2'd3) |-> sym_phase[0]);
endmodule

// File: tb/tb_psk_mapper_top.sv
`timescale 1ns/1ps
module tb_psk_mapper_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b01;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        bit_ready;
  logic        sym_valid;
  logic        sym_ready = 1'b1;
  logic [3:0]  sym_phase;
  logic [15:0] sym_cos, sym_sin;
  logic [1:0]  sym_order;

  int checks = 0, fails = 0, cycles = 0, ready_mode = 0;
  int exp_q[$];
  int m_cnt = 0, m_ord = 1, m_lbl = 0;
  bit hold_prev = 0;
  int hold_ph = 0, hold_ord = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  psk_mapper_top dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_phase(sym_phase), .sym_cos(sym_cos),
    .sym_sin(sym_sin), .sym_order(sym_order)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic int sel_ord(input int s);
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int exp_phase(input int ord, input int lbl);
    if (ord == 1) return lbl[0] ? 8 : 0;
    if (ord == 2) begin
      case (lbl & 3) 3: return 2; 1: return 6; 0: return 10; default: return 14; endcase
    end
    case (lbl & 7)
      7: return 1; 5: return 3; 4: return 5; 6: return 7;
      2: return 9; 0: return 11; 1: return 13; default: return 15;
    endcase
  endfunction

  function automatic int exp_trig(input int k, input bit want_sin);
    real a, v;
    a = k * 3.14159265358979 / 8.0;
    v = 32767.0 * (want_sin ? $sin(a) : $cos(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog expired", cycles, 150000);
      report();
    end
    #1;
    case (ready_mode)
      0: sym_ready = 1'b1;
      1: sym_ready = ($urandom % 2) == 0;
      default: sym_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        chk(sym_valid && int'(sym_phase) == hold_ph && int'(sym_order) == hold_ord,
            "R10 held symbol changed", int'(sym_phase), hold_ph);
      end
      hold_prev = sym_valid && !sym_ready;
      hold_ph = int'(sym_phase);
      hold_ord = int'(sym_order);
      if (sym_valid && !sym_ready) chk(!bit_ready, "R10 bit_ready while stalled", bit_ready, 0);
      if (sym_valid && sym_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 symbol with no bits behind it", 1, 0);
        end else begin
          int e, eo, el, ep;
          e = exp_q.pop_front();
          eo = e >> 3;
          el = e & 7;
          ep = exp_phase(eo, el);
          chk(int'(sym_order) == eo, "R2 R9 group size", int'(sym_order), eo);
          case (eo)
            1: chk(int'(sym_phase) == ep, "R4 R3 bpsk phase", int'(sym_phase), ep);
            2: chk(int'(sym_phase) == ep, "R5 R3 qpsk phase", int'(sym_phase), ep);
            default: chk(int'(sym_phase) == ep, "R6 R3 8psk phase", int'(sym_phase), ep);
          endcase
          chk(int'($signed(sym_cos)) == exp_trig(int'(sym_phase), 0), "R7 cosine",
              int'($signed(sym_cos)), exp_trig(int'(sym_phase), 0));
          chk(int'($signed(sym_sin)) == exp_trig(int'(sym_phase), 1), "R7 sine",
              int'($signed(sym_sin)), exp_trig(int'(sym_phase), 1));
        end
      end
      if (bit_valid && bit_ready) begin
        if (m_cnt == 0) m_ord = sel_ord(int'(mode_sel));
        m_lbl = (m_lbl << 1) | int'(bit_data);
        m_cnt++;
        if (m_cnt == m_ord) begin
          exp_q.push_back((m_ord << 3) | (m_lbl & 7));
          m_cnt = 0;
          m_lbl = 0;
        end
      end
    end
  end

  task automatic send_bit(input bit b);
    bit_valid = 1'b1;
    bit_data = b;
    do @(negedge clk); while (!bit_ready);
    @(posedge clk);
    #1;
    bit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_group(input int ord, input int lbl);
    for (int i = ord - 1; i >= 0; i--) send_bit(lbl[i]);
  endtask

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sym_valid, "R1 sym_valid after reset", sym_valid, 0);
    chk(bit_ready, "R1 bit_ready after reset", bit_ready, 1);
    @(posedge clk);
    #1;

    // R8 and R10: latency and stall with sink blocked
    ready_mode = 2;
    idle(1);
    mode_sel = 2'b01;
    send_bit(1'b1);
    @(negedge clk);
    chk(sym_valid && sym_phase == 4'd8, "R8 symbol one cycle after last bit", int'(sym_phase), 8);
    chk(!bit_ready, "R10 input stalled", bit_ready, 0);
    @(posedge clk);
    #1;
    idle(4);
    ready_mode = 0;
    idle(3);

    // every label of every order, MSB first (R3 R4 R5 R6), incl. select 00 (R2)
    mode_sel = 2'b00;
    send_group(1, 0);
    send_group(1, 1);
    mode_sel = 2'b10;
    for (int l = 0; l < 4; l++) send_group(2, l);
    mode_sel = 2'b11;
    for (int l = 0; l < 8; l++) send_group(3, l);

    // R9: change of select in the middle of a group
    mode_sel = 2'b10;
    send_bit(1'b1);
    mode_sel = 2'b11;
    send_bit(1'b0);
    send_group(3, 7);
    idle(3);
    chk(exp_q.size() == 0, "R9 R10 queue after deferred change", exp_q.size(), 0);

    // random traffic with random back-pressure and select changes
    ready_mode = 1;
    for (int i = 0; i < 900; i++) begin
      if ($urandom % 6 == 0) mode_sel = 2'($urandom % 4);
      send_bit(1'($urandom % 2));
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    while (m_cnt != 0) send_bit(1'($urandom % 2));
    ready_mode = 0;
    idle(10);
    chk(exp_q.size() == 0 && !sym_valid, "R10 every bit emitted", exp_q.size(), 0);
    report();
  end
endmodule